// File: doc/BRIEF.md
# Socket Status Change Interrupt Unit

This unit watches the raw signals of a removable-card socket: the two card-detect contacts, the ready/busy line, write protect, the two battery-voltage levels and the socket's power-good indication. It brings every pin into the clock domain through a two-flop synchronizer. It also debounces the two detect contacts, because they bounce when a card is inserted or pulled. The resulting levels are shown in a socket status register. A card counts as present only when both detect contacts are made.

Transitions of interest are recorded as sticky flags in a change register. Three sources are tracked: the card-detect state, a battery warning and a dead battery. Reading the change register returns the flags and clears them. A configuration register enables each source on its own and picks the 4-bit interrupt line number. Host software reads and writes the three registers through a small strobe-based port with a 2-bit index. The unit drives one interrupt request and the line number it is routed to.

Top module: `sock_chg_irq`

## Requirements
- R1: Index 0 reads the socket status: bit 7 is 0, bit 6 power good, bit 5 ready, bit 4 write protect, bit 3 detect B (debounced), bit 2 detect A (debounced), bits 1:0 the battery code. Non-detect fields lag their pins by the two synchronizer stages.
- R2: `socket_full` is 1 exactly when both debounced detect levels are 1.
- R3: A detect level changes only after its synchronized pin has differed from it for DEB_CYCLES consecutive clocks. A shorter pulse leaves the level and the change flags untouched.
- R4: Any change of either debounced detect level sets change bit 3.
- R5: A transition of the synchronized battery code into 01 sets change bit 1 (warning).
- R6: A transition of the synchronized battery code into 00 or 10 sets change bit 0 (dead).
- R7: Index 1 reads the change flags in bits 3, 1 and 0, with all other bits 0. A read strobe at index 1 clears the flags at that clock edge. An event seen at the same edge stays set.
- R8: Index 2 is the configuration register. Bits 7:4 are the interrupt line number and drive `irq_num`. Bits 3, 1 and 0 enable the detect, warning and dead sources. Bit 2 always reads 0.
- R9: `irq` is 1 while any change flag is set together with its enable bit. It drops in the cycle after the clearing read.
- R10: Writes to index 0 and index 1 have no effect, and index 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| det_a_i | input | 1 | Card-detect contact A, 1 = made |
| det_b_i | input | 1 | Card-detect contact B, 1 = made |
| ready_i | input | 1 | Card ready (not busy) |
| wprot_i | input | 1 | Write-protect switch |
| bvd_i | input | 2 | Battery voltage levels |
| pwr_ok_i | input | 1 | Socket power good |
| reg_addr | input | 2 | Register index |
| reg_rd | input | 1 | Read strobe, one clock |
| reg_wr | input | 1 | Write strobe, one clock |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current index, combinational |
| irq | output | 1 | Change interrupt request |
| irq_num | output | 4 | Interrupt line number |
| socket_full | output | 1 | Card present |

## Verification
The assertions assume that `reg_rd` and `reg_wr` are single-clock strobes that are never raised together. They also assume that a strobe's index and data are steady at the clock edge that takes it. The bench drives every strobe, index and pin change half a period away from the rising edge and holds it for a whole cycle. Pin pulses used to probe the debouncer are deliberately shorter than DEB_CYCLES. Every settled change is held well beyond the two synchronizer stages plus the debounce window before the flags are read.

// File: rtl/sci_pkg.sv
package sci_pkg;
    localparam logic [1:0] IDX_STAT = 2'd0;
    localparam logic [1:0] IDX_CHG  = 2'd1;
    localparam logic [1:0] IDX_CFG  = 2'd2;

    // writable bits of the configuration register (bit 2 reserved)
    localparam logic [7:0] CFG_WMASK = 8'hFB;

    typedef struct packed {
        logic cd;     // detect change, reads as bit 3
        logic bwarn;  // battery warning, reads as bit 1
        logic bdead;  // battery dead, reads as bit 0
    } chg_t;
endpackage

// File: rtl/sci_sync.sv
module sci_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/sci_debounce.sv
module sci_debounce #(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_s,
    output logic level,
    output logic flip
);
    localparam int          CW   = $clog2(DEB_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    typedef struct packed {
        logic          level;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (in_s != st_q.level) begin
            if (st_q.cnt == LAST) begin
                st_d.level = in_s;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.level;
    assign flip  = st_d.level ^ st_q.level;
endmodule

// File: rtl/sock_chg_irq.sv
module sock_chg_irq
    import sci_pkg::*;
#(
    parameter int DEB_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       det_a_i,
    input  logic       det_b_i,
    input  logic       ready_i,
    input  logic       wprot_i,
    input  logic [1:0] bvd_i,
    input  logic       pwr_ok_i,
    input  logic [1:0] reg_addr,
    input  logic       reg_rd,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic [3:0] irq_num,
    output logic       socket_full
);
    localparam int NDET = 2;
    localparam int NPIN = NDET + 5;

    typedef struct packed {
        chg_t       chg;
        logic [7:0] cfg;
        logic [1:0] bvd_prev;
    } st_t;

    st_t st_d, st_q;

    logic [NPIN-1:0] pins_raw, pins_s;
    logic [NDET-1:0] det_s, det_lvl, det_flip;
    logic [1:0]      bvd_s;

    // {power, ready, wprot, det_b, det_a, bvd[1:0]}
    assign pins_raw = {pwr_ok_i, ready_i, wprot_i, det_b_i, det_a_i, bvd_i};

    sci_sync #(.W(NPIN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pins_raw),
        .q    (pins_s)
    );

    assign det_s = pins_s[3:2];
    assign bvd_s = pins_s[1:0];

    for (genvar i = 0; i < NDET; i++) begin : g_deb
        sci_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
            .clk  (clk),
            .rst_n(rst_n),
            .in_s (det_s[i]),
            .level(det_lvl[i]),
            .flip (det_flip[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (reg_rd && reg_addr == IDX_CHG) st_d.chg = '0;
        if (|det_flip) st_d.chg.cd = 1'b1;
        if (bvd_s != st_q.bvd_prev) begin
            if (bvd_s == 2'b01) st_d.chg.bwarn = 1'b1;
            if (bvd_s[0] == 1'b0) st_d.chg.bdead = 1'b1;
        end
        st_d.bvd_prev = bvd_s;
        if (reg_wr && reg_addr == IDX_CFG) st_d.cfg = reg_wdata & CFG_WMASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (reg_addr)
            IDX_STAT: reg_rdata = {1'b0, pins_s[6:4], det_lvl[1], det_lvl[0], bvd_s};
            IDX_CHG:  reg_rdata = {4'b0, st_q.chg.cd, 1'b0, st_q.chg.bwarn, st_q.chg.bdead};
            IDX_CFG:  reg_rdata = st_q.cfg;
            default:  reg_rdata = 8'h00;
        endcase
    end

    assign irq = (st_q.chg.cd    & st_q.cfg[3])
               | (st_q.chg.bwarn & st_q.cfg[1])
               | (st_q.chg.bdead & st_q.cfg[0]);
    assign irq_num     = st_q.cfg[7:4];
    assign socket_full = &det_lvl;
endmodule

// File: rtl/sock_chg_irq_chk.sv
module sock_chg_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_addr,
    input logic       reg_rd,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       irq,
    input logic [3:0] irq_num,
    input logic       socket_full
);
    p_status_msb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == 2'd0 |-> reg_rdata[7] == 1'b0);

    p_full_matches_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == 2'd0 |-> socket_full == (reg_rdata[3] && reg_rdata[2]));

    p_chg_layout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == 2'd1 |-> (reg_rdata[7:4] == 4'h0 && reg_rdata[2] == 1'b0));

    p_irqnum_from_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2) |=> irq_num == $past(reg_wdata[7:4]));

    p_cfg_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == 2'd2 |-> reg_rdata[2] == 1'b0);

    p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2 && reg_wdata[3] == 1'b0 &&
         reg_wdata[1] == 1'b0 && reg_wdata[0] == 1'b0) |=> !irq);

    p_unused_index_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == 2'd3 |-> reg_rdata == 8'h00);
endmodule

bind sock_chg_irq sock_chg_irq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq        (irq),
    .irq_num    (irq_num),
    .socket_full(socket_full)
);

// File: tb/tb_sock_chg_irq.sv
module tb_sock_chg_irq;
    localparam int DEB = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n;
    logic       det_a, det_b, rdy, wp, pwr;
    logic [1:0] bvd;
    logic [1:0] addr;
    logic       rd, wr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       irq;
    logic [3:0] irq_num;
    logic       full;

    sock_chg_irq #(.DEB_CYCLES(DEB)) dut (
        .clk(clk), .rst_n(rst_n),
        .det_a_i(det_a), .det_b_i(det_b), .ready_i(rdy), .wprot_i(wp),
        .bvd_i(bvd), .pwr_ok_i(pwr),
        .reg_addr(addr), .reg_rd(rd), .reg_wr(wr), .reg_wdata(wdata),
        .reg_rdata(rdata), .irq(irq), .irq_num(irq_num), .socket_full(full)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // stimulus pins applied at the next cycle: {pwr, rdy, wp, det_b, det_a, bvd}
    logic [6:0] stim;
    logic [7:0] last_rd;

    // reference model state
    logic [6:0] m_s1, m_s2;
    logic       m_lv_a, m_lv_b;
    int         m_cnt_a, m_cnt_b;
    logic [1:0] m_bprev;
    logic [7:0] m_chg, m_cfg;

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_status();
        return {1'b0, m_s2[6:4], m_lv_b, m_lv_a, m_s2[1:0]};
    endfunction

    function automatic logic m_irq();
        return |(m_chg & m_cfg & 8'h0B);
    endfunction

    task automatic model_step();
        logic [7:0] nchg;
        logic na, nb;
        nchg = (rd && addr == 2'd1) ? 8'h00 : m_chg;
        na = m_lv_a;
        nb = m_lv_b;
        if (m_s2[2] != m_lv_a) begin
            if (m_cnt_a == DEB - 1) begin na = m_s2[2]; m_cnt_a = 0; end
            else m_cnt_a++;
        end else m_cnt_a = 0;
        if (m_s2[3] != m_lv_b) begin
            if (m_cnt_b == DEB - 1) begin nb = m_s2[3]; m_cnt_b = 0; end
            else m_cnt_b++;
        end else m_cnt_b = 0;
        if (na != m_lv_a || nb != m_lv_b) nchg[3] = 1'b1;
        if (m_s2[1:0] != m_bprev) begin
            if (m_s2[1:0] == 2'b01) nchg[1] = 1'b1;
            if (m_s2[1:0] == 2'b00 || m_s2[1:0] == 2'b10) nchg[0] = 1'b1;
        end
        m_bprev = m_s2[1:0];
        m_lv_a = na;
        m_lv_b = nb;
        m_s2 = m_s1;
        m_s1 = {pwr, rdy, wp, det_b, det_a, bvd};
        if (wr && addr == 2'd2) m_cfg = wdata & 8'hFB;
        m_chg = nchg;
    endtask

    task automatic cyc(logic r, logic w, logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        chk("R9 irq vs model", {7'b0, irq}, {7'b0, m_irq()});
        chk("R8 irq_num vs model", {4'b0, irq_num}, {4'b0, m_cfg[7:4]});
        chk("R2 socket_full vs model", {7'b0, full}, {7'b0, m_lv_a & m_lv_b});
        {pwr, rdy, wp, det_b, det_a, bvd} = stim;
        rd = r; wr = w; addr = a; wdata = d;
        #1;
        last_rd = rdata;
        if (r) begin
            case (a)
                2'd0: chk("R1 status read vs model", rdata, m_status());
                2'd1: chk("R7 change read vs model", rdata, m_chg);
                2'd2: chk("R8 config read vs model", rdata, m_cfg);
                default: chk("R10 unused read vs model", rdata, 8'h00);
            endcase
        end
        model_step();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd0, 8'h00);
    endtask

    task automatic rd_exp(logic [1:0] a, logic [7:0] exp, string tag);
        cyc(1'b1, 1'b0, a, 8'h00);
        chk(tag, last_rd, exp);
    endtask

    task automatic wr_reg(logic [1:0] a, logic [7:0] d);
        cyc(1'b0, 1'b1, a, d);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        stim = 7'b1_0_0_0_0_11;
        {pwr, rdy, wp, det_b, det_a, bvd} = stim;
        rd = 0; wr = 0; addr = 0; wdata = 0;
        m_s1 = '0; m_s2 = '0; m_lv_a = 0; m_lv_b = 0; m_cnt_a = 0; m_cnt_b = 0;
        m_bprev = '0; m_chg = '0; m_cfg = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_step();

        // reset state
        idle(4);
        chk("R9 reset irq", {7'b0, irq}, 8'h00);
        chk("R2 reset socket_full", {7'b0, full}, 8'h00);
        rd_exp(2'd0, 8'h43, "R1 status after reset");
        rd_exp(2'd1, 8'h00, "R7 change after reset");

        // configuration, reserved bit masked
        wr_reg(2'd2, 8'h5F);
        rd_exp(2'd2, 8'h5B, "R8 config bit2 reads 0");
        chk("R8 irq_num", {4'b0, irq_num}, 8'h05);

        // insertion of a card
        stim = 7'b1_1_0_1_1_11;
        idle(25);
        chk("R2 both detects give full", {7'b0, full}, 8'h01);
        chk("R9 irq on detect change", {7'b0, irq}, 8'h01);
        rd_exp(2'd0, 8'h6F, "R1 status with card");
        rd_exp(2'd1, 8'h08, "R4 detect change flag");
        idle(1);
        chk("R9 irq drops after read", {7'b0, irq}, 8'h00);

        // short bounce on detect A is filtered
        stim = 7'b1_1_0_1_0_11;
        idle(8);
        stim = 7'b1_1_0_1_1_11;
        idle(30);
        chk("R3 bounce keeps full", {7'b0, full}, 8'h01);
        rd_exp(2'd1, 8'h00, "R3 bounce sets no flag");

        // one contact lost
        stim = 7'b1_1_0_0_1_11;
        idle(25);
        chk("R2 one detect is not full", {7'b0, full}, 8'h00);
        rd_exp(2'd1, 8'h08, "R4 single line change");
        rd_exp(2'd0, 8'h67, "R1 status one detect");

        // battery codes
        stim = 7'b1_1_0_0_1_01;
        idle(4);
        chk("R9 irq on warning", {7'b0, irq}, 8'h01);
        rd_exp(2'd1, 8'h02, "R5 warning on 01");
        stim = 7'b1_1_0_0_1_00;
        idle(4);
        rd_exp(2'd1, 8'h01, "R6 dead on 00");
        stim = 7'b1_1_0_0_1_10;
        idle(4);
        rd_exp(2'd1, 8'h01, "R6 dead on 10");
        stim = 7'b1_1_0_0_1_11;
        idle(4);
        rd_exp(2'd1, 8'h00, "R6 return to 11 no flag");

        // read-only and unused indices
        wr_reg(2'd1, 8'hFF);
        wr_reg(2'd0, 8'hFF);
        idle(1);
        rd_exp(2'd1, 8'h00, "R10 write to change ignored");
        rd_exp(2'd0, 8'h67, "R10 write to status ignored");
        rd_exp(2'd3, 8'h00, "R10 unused index");
        rd_exp(2'd2, 8'h5B, "R10 config untouched");

        // write protect visible
        stim = 7'b1_1_1_0_1_11;
        idle(3);
        rd_exp(2'd0, 8'h77, "R1 write protect bit");

        // sources masked
        wr_reg(2'd2, 8'h30);
        stim = 7'b1_1_1_0_1_01;
        idle(4);
        chk("R9 masked source no irq", {7'b0, irq}, 8'h00);
        chk("R8 irq_num after rewrite", {4'b0, irq_num}, 8'h03);
        rd_exp(2'd1, 8'h02, "R7 flag held while masked");
        idle(2);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule